// File: doc/BRIEF.md
# SDLC Receive Address Filter

This block sits behind a bit-level SDLC/HDLC receiver that has already found the opening and closing flags (01111110) and removed the stuffed zero bits. It takes that receiver's output as a byte stream with separate frame-start and frame-end markers. It treats the first byte after each start marker as the address field and decides whether the frame is for this station. An accepted frame is passed on, starting with its address byte. A rejected frame is dropped whole.

Four control inputs set the behaviour: a receive enable, an address-search enable, a group-match option and the station address. When the group option is set, only the upper four address bits are compared. One station address setting then accepts frames from a group of up to sixteen sources, although the address field on the line stays a full byte. The control settings are captured when a frame starts and stay fixed for the whole of that frame. The output stream carries start and end markers of its own and a frame-accepted level.

Top module: `sdlc_addr_filter`

## Requirements
- R1: After reset every output is low and no frame is in progress. A byte that arrives without a preceding start marker produces no output.
- R2: While `rx_en` is 0, start markers, bytes and end markers are ignored, and `out_valid` and `out_eof` stay low in the following cycle.
- R3: With `srch_en` = 0, every frame is passed whatever its address byte, and the state of `grp_en` makes no difference.
- R4: With `srch_en` = 1 and `grp_en` = 0, a frame is passed only when all 8 bits of the address byte equal `stn_addr`.
- R5: With `srch_en` = 1 and `grp_en` = 1, a frame is passed when bits 7:4 of the address byte equal bits 7:4 of `stn_addr`. Bits 3:0 are not compared.
- R6: With `srch_en` = 1, the address byte 0xFF is always accepted, in either compare mode.
- R7: For an accepted frame, the address byte appears on `out_data` with `out_valid` and `out_sof` high exactly one cycle after it is input. Each later byte follows with the same one-cycle latency. `out_eof` pulses one cycle after the input end marker. `frm_acc` is high from the `out_sof` cycle through the `out_eof` cycle and low in the cycle after. A rejected frame produces no output at all.
- R8: A frame whose end marker arrives before any address byte is discarded and produces no output.
- R9: Clearing `rx_en` during a frame abandons that frame at once. No `out_eof` is produced for it, and `frm_acc` is low in the next cycle. Bytes that arrive after that are ignored until a new start marker.
- R10: `srch_en`, `grp_en` and `stn_addr` are sampled with the start marker. A change made after that takes effect only from the next frame.
- R11: A start marker that arrives inside a frame ends the old frame without an `out_eof` and begins a new address decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| srch_en | input | 1 | Address-search enable |
| grp_en | input | 1 | Compare only the upper address nibble |
| stn_addr | input | 8 | Station address |
| in_sof | input | 1 | Frame-start marker (carries no byte) |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| in_eof | input | 1 | Frame-end marker (carries no byte) |
| out_valid | output | 1 | Output byte strobe |
| out_sof | output | 1 | Marks the first (address) output byte |
| out_data | output | 8 | Output byte |
| out_eof | output | 1 | Frame-end pulse for an accepted frame |
| frm_acc | output | 1 | Current frame accepted |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 4-bit group field and broadcast recognition enabled. These values make the exact-match, upper-nibble and all-ones cases reachable with ordinary byte values, so one vector table can cover every compare mode. With the same defaults the directed tests reach the sequencing cases: an end marker before any address, the enable dropping mid-frame, a restart mid-frame and a settings change between the start marker and the address byte.

// File: rtl/sdlc_filt_pkg.sv
// Package: shared types for the receive address filter.
// Assumes: one frame-level state machine and a captured mode word per frame.
package sdlc_filt_pkg;

    // Frame progress as seen by the filter
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // outside any frame
        ST_ADDR = 2'd1,   // start seen, waiting for the address byte
        ST_PASS = 2'd2,   // frame accepted, forwarding
        ST_DROP = 2'd3    // frame rejected, discarding
    } filt_state_e;

    // Compare-mode settings captured at frame start
    typedef struct packed {
        logic srch;   // address search on
        logic grp;    // compare upper group bits only
    } filt_mode_t;

endpackage

// File: rtl/sdlc_cfg_snap.sv
// Module: captures the compare settings when a frame starts.
// Assumes: load is high only for an enabled start marker, so the
// settings stay fixed from one start marker to the next.
module sdlc_cfg_snap
    import sdlc_filt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              srch_in,
    input  logic              grp_in,
    input  logic [ADDR_W-1:0] stn_in,
    output filt_mode_t        mode_q,
    output logic [ADDR_W-1:0] stn_q
);

    // Hold the settings for the frame now in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            stn_q  <= '0;
        end else if (load) begin
            mode_q.srch <= srch_in;
            mode_q.grp  <= grp_in;
            stn_q       <= stn_in;
        end
    end

endmodule

// File: rtl/sdlc_addr_match.sv
// Module: combinational accept decision for one address byte.
// Assumes: the mode and station address come from the per-frame capture.
// GRP_BITS upper bits are compared in group mode. A value of ADDR_W or
// more makes group mode the same as a full compare.
module sdlc_addr_match
    import sdlc_filt_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int GRP_BITS = 4,
    parameter bit BCAST_EN = 1'b1
) (
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [ADDR_W-1:0] stn,
    input  filt_mode_t        mode,
    output logic              accept
);

    localparam logic [ADDR_W-1:0] BCAST_VAL = '1;

    logic full_hit;
    logic grp_hit;
    logic bcast_hit;

    // Compare every address bit
    always_comb full_hit = (rx_addr == stn);

    generate
        if (GRP_BITS >= ADDR_W) begin : g_grp_full
            // Group field covers the whole byte
            always_comb grp_hit = full_hit;
        end else begin : g_grp_part
            // Compare only the upper group field
            always_comb grp_hit =
                (rx_addr[ADDR_W-1 -: GRP_BITS] == stn[ADDR_W-1 -: GRP_BITS]);
        end

        if (BCAST_EN) begin : g_bcast
            // Recognise the all-ones address
            always_comb bcast_hit = (rx_addr == BCAST_VAL);
        end else begin : g_no_bcast
            // No broadcast recognition in this build
            always_comb bcast_hit = 1'b0;
        end
    endgenerate

    // Combine the hits according to the captured mode
    always_comb begin
        if (!mode.srch)     accept = 1'b1;
        else if (bcast_hit) accept = 1'b1;
        else if (mode.grp)  accept = grp_hit;
        else                accept = full_hit;
    end

endmodule

// File: rtl/sdlc_filt_fsm.sv
// Module: frame state machine. It tracks the frame, makes the address
// decision and issues emit and abandon strobes to the output stage.
// Assumes: in_sof, in_valid and in_eof come from the flag detector and
// at most one of them is high in a cycle. If several are high, the
// priority is enable loss, then start, then end, then byte.
module sdlc_filt_fsm
    import sdlc_filt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic in_sof,
    input  logic in_valid,
    input  logic in_eof,
    input  logic accept,
    output logic load_cfg,
    output logic emit_first,
    output logic emit_byte,
    output logic emit_end,
    output logic abandon
);

    filt_state_e state_q;
    filt_state_e state_d;

    // Capture the settings on every enabled start marker
    always_comb load_cfg = rx_en & in_sof;

    // Next state and strobes for this cycle
    always_comb begin
        state_d    = state_q;
        emit_first = 1'b0;
        emit_byte  = 1'b0;
        emit_end   = 1'b0;
        abandon    = 1'b0;
        if (!rx_en) begin
            state_d = ST_IDLE;
            abandon = (state_q != ST_IDLE);
        end else if (in_sof) begin
            state_d = ST_ADDR;
            abandon = (state_q == ST_PASS);
        end else if (in_eof) begin
            emit_end = (state_q == ST_PASS);
            state_d  = ST_IDLE;
        end else if (in_valid) begin
            unique case (state_q)
                ST_ADDR: begin
                    if (accept) begin
                        emit_first = 1'b1;
                        state_d    = ST_PASS;
                    end else begin
                        state_d    = ST_DROP;
                    end
                end
                ST_PASS: emit_byte = 1'b1;
                default: state_d   = state_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/sdlc_out_stage.sv
// Module: registered output stage. It drives the byte stream, the frame
// markers and the accepted level.
// Assumes: the emit strobes from the state machine are mutually exclusive.
// The accepted level rises with the first byte and clears one cycle after
// the end pulse, or at once on abandon.
module sdlc_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit_first,
    input  logic              emit_byte,
    input  logic              emit_end,
    input  logic              abandon,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic [DATA_W-1:0] out_data,
    output logic              frm_acc
);

    // Register the strobes and markers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
        end else begin
            out_valid <= emit_first | emit_byte;
            out_sof   <= emit_first;
            out_eof   <= emit_end;
        end
    end

    // Register the byte only when it is forwarded
    always_ff @(posedge clk) begin
        if (!rst_n)                       out_data <= '0;
        else if (emit_first || emit_byte) out_data <= in_data;
    end

    // Accepted level for the frame on the output
    always_ff @(posedge clk) begin
        if (!rst_n)                  frm_acc <= 1'b0;
        else if (emit_first)         frm_acc <= 1'b1;
        else if (abandon || out_eof) frm_acc <= 1'b0;
    end

endmodule

// File: rtl/sdlc_addr_filter.sv
// Module: top of the receive address filter.
// Assumes: the input comes from a flag detector and zero-bit remover.
// Start and end markers carry no byte, and the first byte after a start
// marker is the address field. The output has one cycle of latency.
module sdlc_addr_filter
    import sdlc_filt_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int GRP_BITS = 4,
    parameter bit BCAST_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              srch_en,
    input  logic              grp_en,
    input  logic [ADDR_W-1:0] stn_addr,
    input  logic              in_sof,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_data,
    input  logic              in_eof,
    output logic              out_valid,
    output logic              out_sof,
    output logic [ADDR_W-1:0] out_data,
    output logic              out_eof,
    output logic              frm_acc
);

    filt_mode_t        mode_q;
    logic [ADDR_W-1:0] stn_q;
    logic              accept;
    logic              load_cfg;
    logic              emit_first;
    logic              emit_byte;
    logic              emit_end;
    logic              abandon;

    sdlc_cfg_snap #(.ADDR_W(ADDR_W)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_cfg),
        .srch_in (srch_en),
        .grp_in  (grp_en),
        .stn_in  (stn_addr),
        .mode_q  (mode_q),
        .stn_q   (stn_q)
    );

    sdlc_addr_match #(
        .ADDR_W   (ADDR_W),
        .GRP_BITS (GRP_BITS),
        .BCAST_EN (BCAST_EN)
    ) match_i (
        .rx_addr (in_data),
        .stn     (stn_q),
        .mode    (mode_q),
        .accept  (accept)
    );

    sdlc_filt_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .in_sof     (in_sof),
        .in_valid   (in_valid),
        .in_eof     (in_eof),
        .accept     (accept),
        .load_cfg   (load_cfg),
        .emit_first (emit_first),
        .emit_byte  (emit_byte),
        .emit_end   (emit_end),
        .abandon    (abandon)
    );

    sdlc_out_stage #(.DATA_W(ADDR_W)) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .emit_first (emit_first),
        .emit_byte  (emit_byte),
        .emit_end   (emit_end),
        .abandon    (abandon),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_sof    (out_sof),
        .out_eof    (out_eof),
        .out_data   (out_data),
        .frm_acc    (frm_acc)
    );

endmodule

// File: rtl/sdlc_addr_filter_chk.sv
// Module: property checker for the receive address filter.
// Assumes: it is attached to every instance of the top by the bind below
// and watches only the top-level ports.
module sdlc_addr_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic out_valid,
    input logic out_sof,
    input logic out_eof,
    input logic frm_acc
);

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!out_valid && !out_eof));                    // R2
    AST_SOF_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);                                  // R7
    AST_BYTE_IN_ACC_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> frm_acc);                                  // R7
    AST_EOF_IN_ACC_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> frm_acc);                                    // R7
    AST_ACC_STARTS_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_acc) |-> out_sof);                             // R7
    AST_ACC_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |=> !frm_acc);                                   // R7
    AST_ABANDON_ON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_acc && !rx_en) |=> !frm_acc);                       // R9

endmodule

bind sdlc_addr_filter sdlc_addr_filter_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .frm_acc   (frm_acc)
);

// File: tb/sdlc_addr_filter_tb.sv
// Bench for the receive address filter. A vector table walks the compare
// modes, then directed tests cover reset and sequencing corners.
module sdlc_addr_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       srch_en = 1'b0;
    logic       grp_en = 1'b0;
    logic [7:0] stn_addr = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_eof = 1'b0;
    logic       out_valid;
    logic       out_sof;
    logic [7:0] out_data;
    logic       out_eof;
    logic       frm_acc;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    sdlc_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .srch_en(srch_en),
        .grp_en(grp_en), .stn_addr(stn_addr), .in_sof(in_sof),
        .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof),
        .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data),
        .out_eof(out_eof), .frm_acc(frm_acc)
    );

    // Vector fields: {srch, grp, station[7:0], address[7:0], expect_pass}
    localparam int NV = 10;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'hA5, 8'hA5, 1'b1},
        {1'b1, 1'b0, 8'hA5, 8'hA4, 1'b0},
        {1'b1, 1'b1, 8'hA5, 8'hA3, 1'b1},
        {1'b1, 1'b1, 8'hA5, 8'hB5, 1'b0},
        {1'b1, 1'b0, 8'hA5, 8'hFF, 1'b1},
        {1'b1, 1'b1, 8'h30, 8'hFF, 1'b1},
        {1'b0, 1'b0, 8'hA5, 8'h12, 1'b1},
        {1'b0, 1'b1, 8'hA5, 8'h12, 1'b1},
        {1'b1, 1'b1, 8'hA0, 8'hAF, 1'b1},
        {1'b1, 1'b0, 8'h01, 8'h10, 1'b0}
    };

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive one input event at the falling edge, then wait one cycle so
    // the outputs show the result of that event.
    task automatic step(input logic s, input logic v, input logic e,
                        input logic [7:0] d);
        in_sof = s; in_valid = v; in_eof = e; in_data = d;
        @(negedge clk);
        in_sof = 1'b0; in_valid = 1'b0; in_eof = 1'b0;
    endtask

    task automatic expect_quiet(input string tag);
        check(tag, "out_valid", out_valid, 0);
        check(tag, "out_eof", out_eof, 0);
        check(tag, "frm_acc", frm_acc, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, and a byte with no start marker
        expect_quiet("R1");
        check("R1", "out_sof", out_sof, 0);
        rx_en = 1'b1;
        step(0, 1, 0, 8'h42);
        expect_quiet("R1");
        step(0, 0, 1, 8'h00);
        expect_quiet("R1");

        // Table walk: R3 R4 R5 R6 and the R7 timing
        for (int i = 0; i < NV; i++) begin
            logic [18:0] v;
            string tag;
            logic ex;
            v = VEC[i];
            srch_en = v[18]; grp_en = v[17]; stn_addr = v[16:9];
            ex = v[0];
            if (!v[18])              tag = "R3";
            else if (v[8:1] == 8'hFF) tag = "R6";
            else if (v[17])          tag = "R5";
            else                     tag = "R4";
            step(1, 0, 0, 8'h00);
            check(tag, "out_valid after start", out_valid, 0);
            step(0, 1, 0, v[8:1]);
            check(tag, "addr out_valid", out_valid, int'(ex));
            check(tag, "addr out_sof", out_sof, int'(ex));
            check(tag, "frm_acc", frm_acc, int'(ex));
            if (ex) check("R7", "addr byte", out_data, int'(v[8:1]));
            step(0, 1, 0, 8'h3C);
            check("R7", "data out_valid", out_valid, int'(ex));
            check("R7", "data out_sof", out_sof, 0);
            if (ex) check("R7", "data byte", out_data, 8'h3C);
            step(0, 0, 1, 8'h00);
            check("R7", "out_eof", out_eof, int'(ex));
            check("R7", "frm_acc at end", frm_acc, int'(ex));
            step(0, 0, 0, 8'h00);
            expect_quiet("R7");
        end

        // R2: receive disabled, whole frame ignored
        srch_en = 1'b0; rx_en = 1'b0;
        step(1, 0, 0, 8'h00);
        step(0, 1, 0, 8'h11);
        expect_quiet("R2");
        step(0, 1, 0, 8'h22);
        expect_quiet("R2");
        step(0, 0, 1, 8'h00);
        expect_quiet("R2");
        rx_en = 1'b1;

        // R8: end marker before any address byte
        step(1, 0, 0, 8'h00);
        step(0, 0, 1, 8'h00);
        expect_quiet("R8");
        step(0, 1, 0, 8'h77);
        expect_quiet("R8");

        // R9: enable dropped mid-frame
        step(1, 0, 0, 8'h00);
        step(0, 1, 0, 8'h44);
        check("R9", "accepted before drop", frm_acc, 1);
        rx_en = 1'b0;
        step(0, 1, 0, 8'h55);
        expect_quiet("R9");
        rx_en = 1'b1;
        step(0, 1, 0, 8'h66);
        expect_quiet("R9");
        step(0, 0, 1, 8'h00);
        expect_quiet("R9");

        // R10: station change after the start marker waits for next frame
        srch_en = 1'b1; grp_en = 1'b0; stn_addr = 8'h55;
        step(1, 0, 0, 8'h00);
        stn_addr = 8'h66;
        step(0, 1, 0, 8'h66);
        expect_quiet("R10");
        step(0, 0, 1, 8'h00);
        expect_quiet("R10");
        step(1, 0, 0, 8'h00);
        step(0, 1, 0, 8'h66);
        check("R10", "new station used", out_sof, 1);
        step(0, 0, 1, 8'h00);
        check("R10", "out_eof", out_eof, 1);
        step(0, 0, 0, 8'h00);

        // R11: start marker inside an accepted frame
        step(1, 0, 0, 8'h00);
        step(0, 1, 0, 8'h66);
        check("R11", "first frame accepted", frm_acc, 1);
        step(1, 0, 0, 8'h00);
        expect_quiet("R11");
        step(0, 1, 0, 8'h67);
        expect_quiet("R11");
        step(0, 0, 1, 8'h00);
        expect_quiet("R11");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule